// File: doc/BRIEF.md
# Target-Side Packet Interface for a Ring Network Node

This block connects a slave host to one port of a ring network node. Request packets arrive from the network as a stream of 32-bit cells. The block rebuilds each request and hands the host a single command: read or write, an address and, for a write, the data word. Each request header is kept in a small pending buffer until the host completes that request. The block then forms the response packet from the stored header and sends it back to the network one cell at a time. A read response carries the returned word. A write response is a bare acknowledgement header.

The block never starts a transaction of its own. Both edges use valid/ready handshakes, and a cell moves only on a cycle where both signals are high. The host must complete its requests in the order it accepted them. Because the pending buffer is strictly first-in first-out, responses of either length leave in request order. A full buffer holds off new request headers, so the network sees backpressure and no header is lost.

Top module: `noc_target_port`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `net_in_ready`=1, `net_out_valid`=0, `host_req_valid`=0, `host_rsp_ready`=0 and `cmd_error`=0.
- R2: Header layout (32 bits): [31:28] destination, [27:24] source, [23:22] command (00 read, 01 write, 10 read response, 11 write response), [21:16] tag, [15:0] reserved. A read request is a header cell followed by an address cell. The cycle after the address cell transfers, `host_req_valid`=1, `host_req_write`=0 and `host_req_addr` equals the address.
- R3: A write request is a header cell, an address cell and a data cell. After the data cell transfers, the host sees `host_req_write`=1 together with the address and the data.
- R4: While `host_req_valid` is high and `host_req_ready` is low, the request fields do not change. No network cell is accepted while a request waits for the host.
- R5: A read response is two cells. The first is a header with destination and source swapped, command 10, the tag kept and reserved bits zero. The second is `host_rsp_rdata`.
- R6: A write response is one header cell with command 11, built the same way as in R5. `host_rsp_rdata` is ignored and no second cell follows.
- R7: Responses leave in the order the requests arrived, each carrying the tag and swapped identifiers of its own request.
- R8: The pending buffer holds PEND_DEPTH (default 4) headers. While it is full, `net_in_ready` is low in the header position.
- R9: A header with a response command (10 or 11) is consumed as a one-cell packet. It produces no host request and sets `cmd_error`, which stays high until reset.
- R10: `host_rsp_ready` is high only while a header is pending and no response is being sent. While `net_out_valid` is high and `net_out_ready` is low, the output cell stays unchanged.
- R11: A header can be stored and a completed response taken on the same cycle. The pending count is then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_in_valid | input | 1 | Request cell valid from network |
| net_in_ready | output | 1 | Block can take a request cell |
| net_in_data | input | 32 | Request cell |
| host_req_valid | output | 1 | Rebuilt request offered to host |
| host_req_ready | input | 1 | Host accepts the request |
| host_req_write | output | 1 | 1 = write, 0 = read |
| host_req_addr | output | 32 | Request address |
| host_req_wdata | output | 32 | Write data (zero for reads) |
| host_rsp_valid | input | 1 | Host completes the oldest accepted request |
| host_rsp_ready | output | 1 | Block can take a completion |
| host_rsp_rdata | input | 32 | Read data (ignored for writes) |
| net_out_valid | output | 1 | Response cell valid |
| net_out_ready | input | 1 | Network takes the response cell |
| net_out_data | output | 32 | Response cell |
| cmd_error | output | 1 | Sticky: a response-coded header was received |

## Verification
The two operations that can meet in one cycle are storing a new request header and releasing the oldest one when the host completes a request. The bench sets up three outstanding requests. It then drives a new header and a host completion at the same falling edge, so both handshakes land on one rising edge. The result is judged at the ports: one more request must fill the buffer exactly, so the next header is refused, and the four responses that follow must drain in order with the right tags.

// File: rtl/ntp_pkg.sv
package ntp_pkg;

    localparam int CELL_W = 32;

    typedef enum logic [1:0] {
        CMD_RD   = 2'b00,
        CMD_WR   = 2'b01,
        CMD_RRSP = 2'b10,
        CMD_WRSP = 2'b11
    } cmd_e;

    typedef struct packed {
        logic [3:0]  dst;
        logic [3:0]  src;
        cmd_e        cmd;
        logic [5:0]  tag;
        logic [15:0] rsvd;
    } hdr_t;

    typedef struct packed {
        logic              write;
        logic [CELL_W-1:0] addr;
        logic [CELL_W-1:0] wdata;
    } host_req_t;

    function automatic logic is_rsp_code(cmd_e c);
        return c[1];
    endfunction

    function automatic hdr_t make_rsp_hdr(hdr_t req);
        hdr_t r;
        r.dst  = req.src;
        r.src  = req.dst;
        r.cmd  = (req.cmd == CMD_WR) ? CMD_WRSP : CMD_RRSP;
        r.tag  = req.tag;
        r.rsvd = '0;
        return r;
    endfunction

endpackage

// File: rtl/ntp_req_parser.sv
module ntp_req_parser
    import ntp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CELL_W-1:0] in_data,
    output logic              hdr_push,
    output hdr_t              hdr_push_data,
    input  logic              hdr_full,
    output logic              bad_cmd,
    output logic              req_valid,
    input  logic              req_ready,
    output host_req_t         req
);

    typedef enum logic [1:0] {P_HDR, P_ADDR, P_DATA, P_HOLD} pstate_e;

    pstate_e state_q;
    host_req_t req_q;
    hdr_t hdr_in;
    logic fire;

    assign hdr_in = hdr_t'(in_data);

    always_comb begin
        case (state_q)
            P_HDR:   in_ready = !hdr_full;
            P_ADDR:  in_ready = 1'b1;
            P_DATA:  in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase
    end

    assign fire          = in_valid && in_ready;
    assign bad_cmd       = fire && (state_q == P_HDR) && is_rsp_code(hdr_in.cmd);
    assign hdr_push      = fire && (state_q == P_HDR) && !is_rsp_code(hdr_in.cmd);
    assign hdr_push_data = hdr_in;
    assign req_valid     = (state_q == P_HOLD);
    assign req           = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_HDR;
            req_q   <= '0;
        end else begin
            case (state_q)
                P_HDR: begin
                    if (hdr_push) begin
                        req_q.write <= (hdr_in.cmd == CMD_WR);
                        state_q     <= P_ADDR;
                    end
                end
                P_ADDR: begin
                    if (fire) begin
                        req_q.addr <= in_data;
                        if (req_q.write) begin
                            state_q <= P_DATA;
                        end else begin
                            req_q.wdata <= '0;
                            state_q     <= P_HOLD;
                        end
                    end
                end
                P_DATA: begin
                    if (fire) begin
                        req_q.wdata <= in_data;
                        state_q     <= P_HOLD;
                    end
                end
                default: begin
                    if (req_ready) begin
                        state_q <= P_HDR;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ntp_hdr_fifo.sv
module ntp_hdr_fifo
    import ntp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  hdr_t push_data,
    input  logic pop,
    output hdr_t pop_data,
    output logic full,
    output logic empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    hdr_t mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic do_push, do_pop;

    assign full     = (count == FULL_CNT);
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (do_push && (wr_ptr == PTR_W'(i))) begin
                    mem[i] <= push_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ntp_rsp_framer.sv
module ntp_rsp_framer
    import ntp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_empty,
    input  hdr_t              pend_hdr,
    output logic              pend_pop,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [CELL_W-1:0] rsp_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CELL_W-1:0] out_data
);

    typedef enum logic [1:0] {F_IDLE, F_HDR, F_DATA} fstate_e;

    fstate_e state_q;
    hdr_t hdr_q;
    logic [CELL_W-1:0] data_q;
    logic has_data_q;
    logic take;

    assign rsp_ready = (state_q == F_IDLE) && !pend_empty;
    assign take      = rsp_valid && rsp_ready;
    assign pend_pop  = take;
    assign out_valid = (state_q != F_IDLE);
    assign out_data  = (state_q == F_DATA) ? data_q : CELL_W'(hdr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= F_IDLE;
            hdr_q      <= '0;
            data_q     <= '0;
            has_data_q <= 1'b0;
        end else begin
            case (state_q)
                F_IDLE: begin
                    if (take) begin
                        hdr_q      <= make_rsp_hdr(pend_hdr);
                        data_q     <= rsp_rdata;
                        has_data_q <= (pend_hdr.cmd == CMD_RD);
                        state_q    <= F_HDR;
                    end
                end
                F_HDR: begin
                    if (out_ready) begin
                        state_q <= has_data_q ? F_DATA : F_IDLE;
                    end
                end
                default: begin
                    if (out_ready) begin
                        state_q <= F_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/noc_target_port.sv
module noc_target_port
    import ntp_pkg::*;
#(
    parameter int PEND_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              net_in_valid,
    output logic              net_in_ready,
    input  logic [CELL_W-1:0] net_in_data,
    output logic              host_req_valid,
    input  logic              host_req_ready,
    output logic              host_req_write,
    output logic [CELL_W-1:0] host_req_addr,
    output logic [CELL_W-1:0] host_req_wdata,
    input  logic              host_rsp_valid,
    output logic              host_rsp_ready,
    input  logic [CELL_W-1:0] host_rsp_rdata,
    output logic              net_out_valid,
    input  logic              net_out_ready,
    output logic [CELL_W-1:0] net_out_data,
    output logic              cmd_error
);

    logic      hdr_push, hdr_pop, hdr_full, hdr_empty, bad_cmd;
    hdr_t      hdr_push_data, hdr_head;
    host_req_t req;
    logic      err_q;

    ntp_req_parser u_parser (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (net_in_valid),
        .in_ready      (net_in_ready),
        .in_data       (net_in_data),
        .hdr_push      (hdr_push),
        .hdr_push_data (hdr_push_data),
        .hdr_full      (hdr_full),
        .bad_cmd       (bad_cmd),
        .req_valid     (host_req_valid),
        .req_ready     (host_req_ready),
        .req           (req)
    );

    ntp_hdr_fifo #(.DEPTH(PEND_DEPTH)) u_pending (
        .clk       (clk),
        .rst       (rst),
        .push      (hdr_push),
        .push_data (hdr_push_data),
        .pop       (hdr_pop),
        .pop_data  (hdr_head),
        .full      (hdr_full),
        .empty     (hdr_empty)
    );

    ntp_rsp_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .pend_empty (hdr_empty),
        .pend_hdr   (hdr_head),
        .pend_pop   (hdr_pop),
        .rsp_valid  (host_rsp_valid),
        .rsp_ready  (host_rsp_ready),
        .rsp_rdata  (host_rsp_rdata),
        .out_valid  (net_out_valid),
        .out_ready  (net_out_ready),
        .out_data   (net_out_data)
    );

    assign host_req_write = req.write;
    assign host_req_addr  = req.addr;
    assign host_req_wdata = req.wdata;
    assign cmd_error      = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (bad_cmd) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ntp_checker.sv
module ntp_checker #(
    parameter int PEND_DEPTH = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        net_in_valid,
    input logic        net_in_ready,
    input logic [31:0] net_in_data,
    input logic        host_req_valid,
    input logic        host_req_ready,
    input logic        host_req_write,
    input logic [31:0] host_req_addr,
    input logic [31:0] host_req_wdata,
    input logic        host_rsp_valid,
    input logic        host_rsp_ready,
    input logic        net_out_valid,
    input logic        net_out_ready,
    input logic [31:0] net_out_data,
    input logic        cmd_error
);

    localparam int CW = $clog2(PEND_DEPTH + 1) + 1;

    logic [CW-1:0] outst;
    logic [1:0]    pos;
    logic          wr;
    logic          in_fire, inc, dec;

    assign in_fire = net_in_valid && net_in_ready;
    assign inc     = in_fire && (pos == 2'd0) && !net_in_data[23];
    assign dec     = host_rsp_valid && host_rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst <= '0;
            pos   <= 2'd0;
            wr    <= 1'b0;
        end else begin
            if (in_fire) begin
                case (pos)
                    2'd0: if (!net_in_data[23]) begin
                        pos <= 2'd1;
                        wr  <= net_in_data[22];
                    end
                    2'd1:    pos <= wr ? 2'd2 : 2'd0;
                    default: pos <= 2'd0;
                endcase
            end
            outst <= outst + CW'(inc) - CW'(dec);
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        host_req_valid && !host_req_ready |=> host_req_valid && $stable(host_req_write)
            && $stable(host_req_addr) && $stable(host_req_wdata));

    assert_in_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        host_req_valid |-> !net_in_ready);

    assert_depth_R8: assert property (@(posedge clk) disable iff (rst)
        outst <= CW'(PEND_DEPTH));

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (pos == 2'd0) && (outst == CW'(PEND_DEPTH)) |-> !net_in_ready);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_error |=> cmd_error);

    assert_rsp_needs_pending_R10: assert property (@(posedge clk) disable iff (rst)
        host_rsp_ready |-> outst != '0);

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
        net_out_valid && !net_out_ready |=> net_out_valid && $stable(net_out_data));

endmodule

bind noc_target_port ntp_checker #(.PEND_DEPTH(PEND_DEPTH)) u_checker (
    .clk            (clk),
    .rst            (rst),
    .net_in_valid   (net_in_valid),
    .net_in_ready   (net_in_ready),
    .net_in_data    (net_in_data),
    .host_req_valid (host_req_valid),
    .host_req_ready (host_req_ready),
    .host_req_write (host_req_write),
    .host_req_addr  (host_req_addr),
    .host_req_wdata (host_req_wdata),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_ready (host_rsp_ready),
    .net_out_valid  (net_out_valid),
    .net_out_ready  (net_out_ready),
    .net_out_data   (net_out_data),
    .cmd_error      (cmd_error)
);

// File: tb/noc_target_port_bench.sv
module noc_target_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        net_in_valid = 1'b0;
    logic        net_in_ready;
    logic [31:0] net_in_data = '0;
    logic        host_req_valid;
    logic        host_req_ready = 1'b0;
    logic        host_req_write;
    logic [31:0] host_req_addr;
    logic [31:0] host_req_wdata;
    logic        host_rsp_valid = 1'b0;
    logic        host_rsp_ready;
    logic [31:0] host_rsp_rdata = '0;
    logic        net_out_valid;
    logic        net_out_ready = 1'b0;
    logic [31:0] net_out_data;
    logic        cmd_error;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    noc_target_port u_noc_target_port (
        .clk            (clk),
        .rst            (rst),
        .net_in_valid   (net_in_valid),
        .net_in_ready   (net_in_ready),
        .net_in_data    (net_in_data),
        .host_req_valid (host_req_valid),
        .host_req_ready (host_req_ready),
        .host_req_write (host_req_write),
        .host_req_addr  (host_req_addr),
        .host_req_wdata (host_req_wdata),
        .host_rsp_valid (host_rsp_valid),
        .host_rsp_ready (host_rsp_ready),
        .host_rsp_rdata (host_rsp_rdata),
        .net_out_valid  (net_out_valid),
        .net_out_ready  (net_out_ready),
        .net_out_data   (net_out_data),
        .cmd_error      (cmd_error)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired (R1..all) actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_req(input logic [3:0] d, input logic [3:0] s,
                                            input logic [1:0] c, input logic [5:0] t,
                                            input logic [15:0] r);
        return {d, s, c, t, r};
    endfunction

    function automatic logic [31:0] mk_rsp(input logic [31:0] q);
        return {q[27:24], q[31:28], (q[22] ? 2'b11 : 2'b10), q[21:16], 16'h0000};
    endfunction

    task automatic put_cell(input logic [31:0] d);
        @(negedge clk);
        net_in_valid = 1'b1;
        net_in_data  = d;
        while (!net_in_ready) @(negedge clk);
        @(negedge clk);
        net_in_valid = 1'b0;
    endtask

    task automatic send_req(input logic [31:0] h, input logic [31:0] a, input logic [31:0] w);
        put_cell(h);
        put_cell(a);
        if (h[22]) put_cell(w);
    endtask

    task automatic take_req(input logic wr, input logic [31:0] a, input logic [31:0] w, input string req);
        @(negedge clk);
        while (!host_req_valid) @(negedge clk);
        check(host_req_write == wr, req, {31'd0, host_req_write}, {31'd0, wr});
        check(host_req_addr == a, req, host_req_addr, a);
        if (wr) check(host_req_wdata == w, req, host_req_wdata, w);
        host_req_ready = 1'b1;
        @(negedge clk);
        host_req_ready = 1'b0;
    endtask

    task automatic give_rsp(input logic [31:0] r);
        @(negedge clk);
        host_rsp_valid = 1'b1;
        host_rsp_rdata = r;
        while (!host_rsp_ready) @(negedge clk);
        @(negedge clk);
        host_rsp_valid = 1'b0;
    endtask

    task automatic get_cell(input logic [31:0] exp, input string req);
        @(negedge clk);
        net_out_ready = 1'b1;
        while (!net_out_valid) @(negedge clk);
        check(net_out_data == exp, req, net_out_data, exp);
        @(negedge clk);
        net_out_ready = 1'b0;
    endtask

    task automatic get_rsp(input logic [31:0] reqh, input logic [31:0] rd, input string req);
        get_cell(mk_rsp(reqh), req);
        if (!reqh[22]) get_cell(rd, req);
        else check(net_out_valid == 1'b0, "R6 no second cell", {31'd0, net_out_valid}, 32'd0);
    endtask

    logic [31:0] hq [6];
    logic [31:0] aq [6];

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(net_out_valid == 1'b0 && host_req_valid == 1'b0, "R1 valids in reset",
              {30'd0, net_out_valid, host_req_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(net_in_ready == 1'b1, "R1 in_ready", {31'd0, net_in_ready}, 32'd1);
        check(host_rsp_ready == 1'b0, "R1 rsp_ready", {31'd0, host_rsp_ready}, 32'd0);
        check(cmd_error == 1'b0, "R1 cmd_error", {31'd0, cmd_error}, 32'd0);
        check(net_out_valid == 1'b0, "R1 out_valid", {31'd0, net_out_valid}, 32'd0);

        // R2 R3 R5 R6: sweep over identifiers, tags and both commands
        for (int i = 0; i < 16; i++) begin
            logic [31:0] h, a, w, r;
            h = mk_req(4'(i), 4'((i * 7 + 3) & 15), {1'b0, i[0]}, 6'((i * 5 + 1) & 63),
                       16'h5A00 | 16'(i));
            a = 32'h1000_0000 + 32'(i) * 32'h44;
            w = ~a;
            r = a ^ 32'hCAFE_0000;
            send_req(h, a, w);
            take_req(i[0], a, w, i[0] ? "R3 write request" : "R2 read request");
            give_rsp(r);
            get_rsp(h, r, i[0] ? "R6 write response" : "R5 read response");
        end

        // R10: output held under stall
        begin
            logic [31:0] h, held;
            h = mk_req(4'h3, 4'hC, 2'b00, 6'h2A, 16'hFFFF);
            send_req(h, 32'hABCD_0000, 32'h0);
            take_req(1'b0, 32'hABCD_0000, 32'h0, "R2 read before stall");
            give_rsp(32'h1234_5678);
            @(negedge clk);
            while (!net_out_valid) @(negedge clk);
            held = net_out_data;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(net_out_valid && net_out_data == held, "R10 stall hold", net_out_data, held);
            end
            get_rsp(h, 32'h1234_5678, "R5 after stall");
        end

        // R8 R7: fill the buffer, then drain in order
        for (int k = 0; k < 4; k++) begin
            hq[k] = mk_req(4'(k + 1), 4'(9 - k), {1'b0, k[0]}, 6'(10 + k * 3), 16'h0F0F);
            aq[k] = 32'h2000_0000 | 32'(k);
            send_req(hq[k], aq[k], ~aq[k]);
            take_req(k[0], aq[k], ~aq[k], "R8 fill");
        end
        @(negedge clk);
        net_in_valid = 1'b1;
        net_in_data  = mk_req(4'h7, 4'h7, 2'b00, 6'h3F, 16'h0);
        check(net_in_ready == 1'b0, "R8 full blocks header", {31'd0, net_in_ready}, 32'd0);
        @(negedge clk);
        check(net_in_ready == 1'b0, "R8 full still blocks", {31'd0, net_in_ready}, 32'd0);
        net_in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            give_rsp(32'h3000_0000 | 32'(k));
            get_rsp(hq[k], 32'h3000_0000 | 32'(k), "R7 in-order drain");
        end

        // R11: store and release on the same cycle
        for (int k = 0; k < 3; k++) begin
            hq[k] = mk_req(4'(k), 4'(k + 4), 2'b00, 6'(20 + k), 16'h0);
            aq[k] = 32'h4000_0000 | 32'(k);
            send_req(hq[k], aq[k], 32'h0);
            take_req(1'b0, aq[k], 32'h0, "R11 setup");
        end
        hq[3] = mk_req(4'hA, 4'h5, 2'b01, 6'h31, 16'h1111);
        aq[3] = 32'h4000_0003;
        fork
            put_cell(hq[3]);
            give_rsp(32'h5000_0000);
        join
        get_rsp(hq[0], 32'h5000_0000, "R11 released response");
        put_cell(aq[3]);
        put_cell(32'hDEAD_BEEF);
        take_req(1'b1, aq[3], 32'hDEAD_BEEF, "R11 stored request");
        hq[4] = mk_req(4'hB, 4'h6, 2'b00, 6'h32, 16'h0);
        aq[4] = 32'h4000_0004;
        send_req(hq[4], aq[4], 32'h0);
        take_req(1'b0, aq[4], 32'h0, "R11 fourth pending");
        @(negedge clk);
        net_in_valid = 1'b1;
        net_in_data  = mk_req(4'h1, 4'h2, 2'b00, 6'h00, 16'h0);
        check(net_in_ready == 1'b0, "R11 count after same-cycle push/pop", {31'd0, net_in_ready}, 32'd0);
        @(negedge clk);
        net_in_valid = 1'b0;
        for (int k = 1; k < 5; k++) begin
            give_rsp(32'h6000_0000 | 32'(k));
            get_rsp(hq[k], 32'h6000_0000 | 32'(k), "R7 R11 drain order");
        end

        // R9: response-coded headers dropped, sticky error
        check(cmd_error == 1'b0, "R9 no error yet", {31'd0, cmd_error}, 32'd0);
        put_cell(mk_req(4'h2, 4'h3, 2'b10, 6'h05, 16'h0));
        check(cmd_error == 1'b1, "R9 error raised", {31'd0, cmd_error}, 32'd1);
        check(host_req_valid == 1'b0, "R9 no host request", {31'd0, host_req_valid}, 32'd0);
        check(net_in_ready == 1'b1, "R9 one-cell packet", {31'd0, net_in_ready}, 32'd1);
        check(host_rsp_ready == 1'b0, "R9 nothing pending", {31'd0, host_rsp_ready}, 32'd0);
        put_cell(mk_req(4'h2, 4'h3, 2'b11, 6'h06, 16'h0));
        check(host_req_valid == 1'b0, "R9 write-rsp code dropped", {31'd0, host_req_valid}, 32'd0);
        begin
            logic [31:0] h;
            h = mk_req(4'h8, 4'h9, 2'b00, 6'h07, 16'h0);
            send_req(h, 32'h7777_0000, 32'h0);
            take_req(1'b0, 32'h7777_0000, 32'h0, "R9 recovery read");
            give_rsp(32'h0BAD_F00D);
            get_rsp(h, 32'h0BAD_F00D, "R9 recovery response");
        end
        check(cmd_error == 1'b1, "R9 error sticky", {31'd0, cmd_error}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule